// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. A shared, free-running main counter is supplied from outside. The channel holds a comparator value and a period, and it raises a one-clock interrupt pulse when the counter reaches the comparator. It can run in two modes:

- **One-shot:** the comparator stays where software put it.
- **Periodic:** after each match the comparator steps forward by the period. If the counter has already run past several periods, the channel keeps stepping until the comparator is ahead of the counter again.

A 32-bit mode restricts the comparator, the period and all comparator arithmetic to the low word. In one-shot 32-bit mode the channel also pulses when the low word of the counter wraps.

Software drives the channel through three write strobes: the config word, the low comparator word and the high comparator word. It reads the config and the comparator back. In periodic mode a comparator write loads the period instead. A self-clearing set-value bit lets the same write also move the comparator. Interrupts leave the channel only while both its own enable and the global enable are set.

Top module: `evt_cmp_channel`

## Requirements
- R1: Reset state. The comparator reads all ones, the period is zero and no pulse is issued. The config word reads 0x300: bit 8 (periodic capable) and bit 9 (64-bit capable) are set, and every control bit is zero.
- R2: Config word layout. Bit 1 is the channel enable, bit 2 periodic, bit 3 set-value and bit 4 32-bit mode; these read back as written. Bit 0 is a level-trigger request, which is ignored and always reads 0: the channel stays edge-triggered with one-clock pulses.
- R3: In one-shot mode a pulse appears on irq_pulse one clock after the counter input reaches the comparator. It appears once only, even while the counter stays on that value.
- R4: The comparator counts as ahead of the counter when the wrapping difference (comparator minus counter) is strictly positive as a signed number. The difference is taken over 64 bits normally and over 32 bits in 32-bit mode.
- R5: In periodic mode with a non-zero period, a due comparator steps by the period once per clock until it is strictly ahead of the counter. A catch-up over several periods produces a single pulse.
- R6: In 32-bit mode the upper words of the comparator and the period are held at zero. Writing 32-bit mode truncates both. High comparator writes change nothing, and the comparator wraps modulo 2^32.
- R7: In one-shot 32-bit mode a pulse is also issued when the low 32 bits of the counter wrap, that is, when they become smaller than on the previous clock. No such pulse is issued in 64-bit mode.
- R8: Comparator writes and the period.
  - A comparator write changes the comparator only when the channel is not periodic or set-value is armed.
  - In periodic mode a low write always loads the low period word, with bit 31 cleared in 32-bit mode.
  - In periodic mode without set-value, a high write loads the high period word with its top bit cleared.
- R9: Set-value clears itself after a write to either comparator word.
- R10: A pulse is issued only when both the channel enable and global_en are set. An event that occurs while either is clear is consumed and does not come back later.
- R11: Any write that changes the comparator re-arms detection. If the new value is not ahead of the counter, a pulse follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_count | input | CNT_W | Shared main counter value |
| global_en | input | 1 | Timer-wide interrupt enable |
| cfg_wr | input | 1 | Write strobe for the config word |
| cfg_wdata | input | WORD_W | Config write data |
| cmp_lo_wr | input | 1 | Write strobe for the low comparator word |
| cmp_hi_wr | input | 1 | Write strobe for the high comparator word |
| cmp_wdata | input | WORD_W | Comparator write data |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| cfg_rdata | output | WORD_W | Config word readback |
| cmp_rdata | output | CNT_W | Comparator readback |

## Verification
The hardest state to reach from the ports is a periodic catch-up that spans several periods. The bench reaches it by loading a period through a set-value write and then moving the counter input past three periods in one step. The bench then counts the clocks until the comparator read-back shows it ahead of the counter again, and confirms that only one pulse was issued. The masked period in 32-bit mode is only visible through the comparator after the first step, so the bench reads the comparator right after that first advance. The low-word wrap pulse is reached by moving the counter across a 2^32 boundary in a single step.

// File: rtl/evtc_pkg.sv
`timescale 1ns/1ps
package evtc_pkg;
   // config word bit positions (software-visible layout)
   localparam int unsigned CFG_LVL  = 0;
   localparam int unsigned CFG_EN   = 1;
   localparam int unsigned CFG_PER  = 2;
   localparam int unsigned CFG_SV   = 3;
   localparam int unsigned CFG_M32  = 4;
   localparam int unsigned CAP_PER  = 8;
   localparam int unsigned CAP_WIDE = 9;

   typedef struct packed {
      logic m32;
      logic sv;
      logic per;
      logic en;
   } chan_cfg_t;
endpackage

// File: rtl/evtc_cfg_reg.sv
`timescale 1ns/1ps
module evtc_cfg_reg
   import evtc_pkg::*;
#(
   parameter int unsigned WORD_W       = 32,
   parameter bit          PERIODIC_CAP = 1'b1,
   parameter bit          WIDE_CAP     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              sv_clr,
   output chan_cfg_t         cfg,
   output logic              trunc,
   output logic [WORD_W-1:0] rdata
);
   logic en_q, per_q, sv_q, m32_q;
   logic per_in, m32_in;
   logic unused_wbits;

   assign unused_wbits = ^wdata;

   generate
      if (PERIODIC_CAP) begin : g_per
         assign per_in = wdata[CFG_PER];
      end else begin : g_no_per
         assign per_in = 1'b0;
      end
      if (WIDE_CAP) begin : g_wide
         assign m32_in = wdata[CFG_M32];
      end else begin : g_narrow
         assign m32_in = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         per_q <= 1'b0;
         sv_q  <= 1'b0;
         m32_q <= !WIDE_CAP;
      end else if (wr) begin
         en_q  <= wdata[CFG_EN];
         per_q <= per_in;
         sv_q  <= wdata[CFG_SV];
         m32_q <= m32_in;
      end else if (sv_clr) begin
         sv_q  <= 1'b0;
      end
   end

   assign trunc = wr && m32_in;

   always_comb begin
      cfg.en  = en_q;
      cfg.per = per_q;
      cfg.sv  = sv_q;
      cfg.m32 = m32_q;
   end

   always_comb begin
      rdata           = '0;
      rdata[CFG_EN]   = en_q;
      rdata[CFG_PER]  = per_q;
      rdata[CFG_SV]   = sv_q;
      rdata[CFG_M32]  = m32_q;
      rdata[CAP_PER]  = PERIODIC_CAP;
      rdata[CAP_WIDE] = WIDE_CAP;
   end
endmodule

// File: rtl/evtc_cmp_store.sv
`timescale 1ns/1ps
module evtc_cmp_store #(
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned WORD_W   = 32,
   parameter bit          WIDE_CAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              per,
   input  logic              sv,
   input  logic              m32,
   input  logic              trunc,
   input  logic              lo_wr,
   input  logic              hi_wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              due,
   output logic [CNT_W-1:0]  cmp_q,
   output logic [CNT_W-1:0]  cmp_nx,
   output logic              upd
);
   localparam int unsigned HI_W = CNT_W - WORD_W;
   localparam logic [CNT_W-1:0] CMP_RST =
      WIDE_CAP ? {CNT_W{1'b1}} : {{HI_W{1'b0}}, {WORD_W{1'b1}}};

   logic [CNT_W-1:0] per_q, per_nx;
   logic             load_cmp, adv;

   assign load_cmp = !per || sv;
   assign adv      = due && per && (per_q != '0);

   always_comb begin
      cmp_nx = cmp_q;
      per_nx = per_q;
      upd    = 1'b0;
      if (lo_wr) begin
         if (load_cmp) begin
            cmp_nx[WORD_W-1:0] = wdata;
            upd = 1'b1;
         end
         if (per)
            per_nx[WORD_W-1:0] = m32 ? {1'b0, wdata[WORD_W-2:0]} : wdata;
      end else if (hi_wr) begin
         if (!m32) begin
            if (load_cmp) begin
               cmp_nx[CNT_W-1:WORD_W] = wdata;
               upd = 1'b1;
            end else begin
               per_nx[CNT_W-1:WORD_W] = {1'b0, wdata[WORD_W-2:0]};
            end
         end
      end else if (adv) begin
         cmp_nx = cmp_q + per_q;
      end
      if (m32 || trunc) begin
         cmp_nx[CNT_W-1:WORD_W] = '0;
         per_nx[CNT_W-1:WORD_W] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= CMP_RST;
         per_q <= '0;
      end else begin
         cmp_q <= cmp_nx;
         per_q <= per_nx;
      end
   end
endmodule

// File: rtl/evtc_match.sv
`timescale 1ns/1ps
module evtc_match #(
   parameter int unsigned CNT_W        = 64,
   parameter int unsigned WORD_W       = 32,
   parameter bit          ONESHOT_WRAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             per,
   input  logic             m32,
   input  logic             gen,
   input  logic             rearm,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp_q,
   input  logic [CNT_W-1:0] cmp_nx,
   output logic             due,
   output logic             irq
);
   logic armed_q, armed_n, hit, wrap;

   function automatic logic ahead_f(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] n,
                                    input logic             narrow);
      logic [CNT_W-1:0] d;
      d = c - n;
      if (narrow)
         return !d[WORD_W-1] && (d[WORD_W-1:0] != '0);
      return !d[CNT_W-1] && (d != '0);
   endfunction

   assign due     = !ahead_f(cmp_q, count, m32);
   assign hit     = armed_q && due;
   assign armed_n = rearm || ahead_f(cmp_nx, count, m32);

   generate
      if (ONESHOT_WRAP) begin : g_wrap
         logic [WORD_W-1:0] prev_lo;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_lo <= '0;
            else        prev_lo <= count[WORD_W-1:0];
         end
         assign wrap = m32 && !per && (count[WORD_W-1:0] < prev_lo);
      end else begin : g_no_wrap
         assign wrap = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         armed_q <= armed_n;
         irq     <= (hit || wrap) && en && gen;
      end
   end
endmodule

// File: rtl/evt_cmp_channel.sv
`timescale 1ns/1ps
module evt_cmp_channel
   import evtc_pkg::*;
#(
   parameter int unsigned CNT_W        = 64,
   parameter int unsigned WORD_W       = 32,
   parameter bit          PERIODIC_CAP = 1'b1,
   parameter bit          WIDE_CAP     = 1'b1,
   parameter bit          ONESHOT_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  main_count,
   input  logic              global_en,
   input  logic              cfg_wr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              cmp_lo_wr,
   input  logic              cmp_hi_wr,
   input  logic [WORD_W-1:0] cmp_wdata,
   output logic              irq_pulse,
   output logic [WORD_W-1:0] cfg_rdata,
   output logic [CNT_W-1:0]  cmp_rdata
);
   generate
      if (CNT_W != 2 * WORD_W) begin : g_bad_split
         $error("evt_cmp_channel: CNT_W must be twice WORD_W");
      end
      if (WORD_W < 16) begin : g_bad_word
         $error("evt_cmp_channel: WORD_W must hold the config layout");
      end
   endgenerate

   chan_cfg_t        cfg;
   logic             trunc, due, upd;
   logic [CNT_W-1:0] cmp_q, cmp_nx;

   evtc_cfg_reg #(
      .WORD_W(WORD_W), .PERIODIC_CAP(PERIODIC_CAP), .WIDE_CAP(WIDE_CAP)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .sv_clr(cmp_lo_wr || cmp_hi_wr), .cfg(cfg), .trunc(trunc),
      .rdata(cfg_rdata)
   );

   evtc_cmp_store #(
      .CNT_W(CNT_W), .WORD_W(WORD_W), .WIDE_CAP(WIDE_CAP)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .per(cfg.per), .sv(cfg.sv), .m32(cfg.m32),
      .trunc(trunc), .lo_wr(cmp_lo_wr), .hi_wr(cmp_hi_wr), .wdata(cmp_wdata),
      .due(due), .cmp_q(cmp_q), .cmp_nx(cmp_nx), .upd(upd)
   );

   evtc_match #(
      .CNT_W(CNT_W), .WORD_W(WORD_W), .ONESHOT_WRAP(ONESHOT_WRAP)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .en(cfg.en), .per(cfg.per), .m32(cfg.m32),
      .gen(global_en), .rearm(upd), .count(main_count), .cmp_q(cmp_q),
      .cmp_nx(cmp_nx), .due(due), .irq(irq_pulse)
   );

   assign cmp_rdata = cmp_q;
endmodule

// File: rtl/evtc_chk.sv
`timescale 1ns/1ps
module evtc_chk
   import evtc_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              global_en,
   input logic              cfg_wr,
   input logic              cmp_lo_wr,
   input logic              cmp_hi_wr,
   input logic [WORD_W-1:0] cmp_wdata,
   input logic              irq_pulse,
   input logic [WORD_W-1:0] cfg_rdata,
   input logic [CNT_W-1:0]  cmp_rdata
);
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (cmp_rdata[WORD_W-1:0] == '1) && !irq_pulse && !cfg_rdata[CFG_EN]);

   assert_level_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[CFG_LVL]);

   assert_pulse_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(global_en) && $past(cfg_rdata[CFG_EN]));

   assert_setval_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_lo_wr || cmp_hi_wr) && !cfg_wr |=> !cfg_rdata[CFG_SV]);

   assert_narrow_high_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[CFG_M32] |-> (cmp_rdata[CNT_W-1:WORD_W] == '0));

   assert_oneshot_lo_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_lo_wr && !cfg_wr && !cfg_rdata[CFG_PER]
      |=> cmp_rdata[WORD_W-1:0] == $past(cmp_wdata));
endmodule

bind evt_cmp_channel evtc_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .global_en(global_en), .cfg_wr(cfg_wr),
   .cmp_lo_wr(cmp_lo_wr), .cmp_hi_wr(cmp_hi_wr), .cmp_wdata(cmp_wdata),
   .irq_pulse(irq_pulse), .cfg_rdata(cfg_rdata), .cmp_rdata(cmp_rdata)
);

// File: tb/evt_cmp_channel_bench.sv
`timescale 1ns/1ps
module evt_cmp_channel_bench;
   localparam int K_NONE = 0, K_CFG = 1, K_LO = 2, K_HI = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] main_count = '0;
   logic        global_en = 1'b0;
   logic        cfg_wr = 1'b0, cmp_lo_wr = 1'b0, cmp_hi_wr = 1'b0;
   logic [31:0] cfg_wdata = '0, cmp_wdata = '0;
   logic        irq_pulse;
   logic [31:0] cfg_rdata;
   logic [63:0] cmp_rdata;

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   logic  exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   evt_cmp_channel u_evt_cmp_channel (
      .clk(clk), .rst_n(rst_n), .main_count(main_count), .global_en(global_en),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cmp_lo_wr(cmp_lo_wr),
      .cmp_hi_wr(cmp_hi_wr), .cmp_wdata(cmp_wdata), .irq_pulse(irq_pulse),
      .cfg_rdata(cfg_rdata), .cmp_rdata(cmp_rdata)
   );

   task automatic check64(input logic [63:0] got, input logic [63:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // driver: one clock per call, expected pulse goes to the scoreboard
   task automatic step(input logic [63:0] c, input int kind, input logic [31:0] d,
                       input logic e, input string tag);
      @(negedge clk);
      main_count = c;
      cfg_wr    = (kind == K_CFG);
      cmp_lo_wr = (kind == K_LO);
      cmp_hi_wr = (kind == K_HI);
      if (kind == K_CFG) cfg_wdata = d;
      else               cmp_wdata = d;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(posedge clk);
      #1;
      cfg_wr = 1'b0; cmp_lo_wr = 1'b0; cmp_hi_wr = 1'b0;
   endtask

   // monitor: compares each registered pulse with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #0.5;
         if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (irq_pulse !== e) begin
               errors++;
               $display("FAIL %s: irq_pulse got %0b expected %0b", t, irq_pulse, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check64(cmp_rdata, 64'hFFFF_FFFF_FFFF_FFFF, "R1 comparator reset");
      check64({32'h0, cfg_rdata}, 64'h300, "R1 config reset");
      step(0, K_NONE, 0, 1'b0, "R1 no pulse after reset");

      // one-shot 64-bit match
      global_en = 1'b1;
      step(0, K_CFG, 32'h2, 1'b0, "R2 enable write");
      step(0, K_HI, 32'h0, 1'b0, "R8 high write");
      step(0, K_LO, 32'd100, 1'b0, "R8 low write");
      check64(cmp_rdata, 64'd100, "R8 one-shot comparator write");
      step(50, K_NONE, 0, 1'b0, "R3 before match");
      step(99, K_NONE, 0, 1'b0, "R3 just before match");
      step(100, K_NONE, 0, 1'b1, "R3 match pulse");
      step(100, K_NONE, 0, 1'b0, "R3 held counter no repeat");
      step(101, K_NONE, 0, 1'b0, "R3 after match");
      step(200, K_NONE, 0, 1'b0, "R3 one-shot stays quiet");

      // level request ignored
      step(200, K_CFG, 32'h3, 1'b0, "R2 level request write");
      check64({32'h0, cfg_rdata}, 64'h302, "R2 level bit reads zero");
      step(200, K_LO, 32'd300, 1'b0, "R2 new comparator");
      step(300, K_NONE, 0, 1'b1, "R2 edge pulse");
      step(300, K_NONE, 0, 1'b0, "R2 single clock pulse");

      // re-arm on a comparator already behind the counter
      step(300, K_LO, 32'd250, 1'b0, "R11 write behind counter");
      step(300, K_NONE, 0, 1'b1, "R11 immediate pulse");
      step(300, K_NONE, 0, 1'b0, "R11 once only");

      // signed 64-bit ahead test across the counter wrap
      step(64'hFFFF_FFFF_FFFF_FFF0, K_NONE, 0, 1'b0, "R4 counter near top");
      step(64'hFFFF_FFFF_FFFF_FFF0, K_LO, 32'h10, 1'b0, "R4 comparator past wrap");
      step(64'hFFFF_FFFF_FFFF_FFF8, K_NONE, 0, 1'b0, "R4 still ahead");
      step(64'h8, K_NONE, 0, 1'b0, "R4 wrapped still ahead");
      step(64'h10, K_NONE, 0, 1'b1, "R4 match after wrap");

      // enable gating
      global_en = 1'b0;
      step(64'h10, K_LO, 32'h20, 1'b0, "R10 write with global off");
      step(64'h20, K_NONE, 0, 1'b0, "R10 global off suppresses");
      global_en = 1'b1;
      step(64'h20, K_NONE, 0, 1'b0, "R10 suppressed event consumed");
      step(64'h20, K_CFG, 32'h0, 1'b0, "R10 channel off");
      step(64'h20, K_LO, 32'h30, 1'b0, "R10 write with channel off");
      step(64'h30, K_NONE, 0, 1'b0, "R10 channel off suppresses");
      step(64'h30, K_CFG, 32'h2, 1'b0, "R10 channel back on");
      step(64'h31, K_NONE, 0, 1'b0, "R10 no late pulse");

      // periodic: write loads period only
      step(64'h31, K_CFG, 32'h6, 1'b0, "R5 periodic on");
      step(64'h31, K_LO, 32'h40, 1'b0, "R8 periodic low write");
      check64(cmp_rdata, 64'h30, "R8 periodic write keeps comparator");
      step(64'h31, K_NONE, 0, 1'b0, "R5 behind comparator advances silently");
      check64(cmp_rdata, 64'h70, "R5 advance by loaded period");
      step(64'h31, K_CFG, 32'hE, 1'b0, "R8 arm set-value");
      step(64'h31, K_LO, 32'h50, 1'b0, "R8 set-value write");
      check64({32'h0, cfg_rdata}, 64'h306, "R9 set-value self clear");
      check64(cmp_rdata, 64'h50, "R8 set-value moves comparator");
      step(64'h50, K_NONE, 0, 1'b1, "R5 first period");
      step(64'h50, K_NONE, 0, 1'b0, "R5 rescheduled ahead");
      step(64'hA0, K_NONE, 0, 1'b1, "R5 second period");
      step(64'hA1, K_NONE, 0, 1'b0, "R5 between periods");
      step(64'h200, K_NONE, 0, 1'b1, "R5 catch-up pulse");
      for (int i = 0; i < 3; i++)
         step(64'h200, K_NONE, 0, 1'b0, "R5 catch-up silent");
      check64(cmp_rdata, 64'h230, "R5 catch-up end value");
      step(64'h230, K_NONE, 0, 1'b1, "R5 after catch-up");

      // 32-bit periodic with top period bit masked
      step(64'h230, K_CFG, 32'h16, 1'b0, "R6 32-bit periodic");
      check64({32'h0, cfg_rdata}, 64'h316, "R2 config readback");
      step(64'h230, K_LO, 32'h8000_0010, 1'b0, "R8 period top bit masked");
      step(64'h290, K_NONE, 0, 1'b1, "R8 32-bit periodic match");
      check64(cmp_rdata, 64'h290, "R8 masked period advance");
      step(64'h290, K_NONE, 0, 1'b0, "R5 32-bit catch-up");
      check64(cmp_rdata, 64'h2A0, "R5 32-bit catch-up end");

      // truncation and ignored high writes
      step(64'h290, K_CFG, 32'h2, 1'b0, "R6 back to 64-bit one-shot");
      step(64'h290, K_HI, 32'h1234, 1'b0, "R6 high word write");
      check64(cmp_rdata, 64'h0000_1234_0000_02A0, "R6 wide comparator");
      step(64'h290, K_CFG, 32'h12, 1'b0, "R6 enter 32-bit");
      check64(cmp_rdata, 64'h2A0, "R6 truncation");
      step(64'h290, K_HI, 32'h55, 1'b0, "R6 high write in 32-bit");
      check64(cmp_rdata, 64'h2A0, "R6 high write ignored");

      // wrap pulse in one-shot 32-bit mode
      step(64'h0000_0000_FFFF_FFF0, K_NONE, 0, 1'b0, "R7 near low wrap");
      step(64'h0000_0001_0000_0005, K_NONE, 0, 1'b1, "R7 wrap pulse");
      step(64'h0000_0001_0000_0006, K_NONE, 0, 1'b0, "R7 after wrap");
      step(64'h0000_0001_0000_02A0, K_NONE, 0, 1'b1, "R6 32-bit match");
      step(64'h0000_0001_0000_02A0, K_CFG, 32'h2, 1'b0, "R7 64-bit mode");
      step(64'h0000_0001_FFFF_FFF0, K_NONE, 0, 1'b0, "R7 64-bit near wrap");
      step(64'h0000_0002_0000_0001, K_NONE, 0, 1'b0, "R7 no wrap pulse in 64-bit");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule